// File: doc/BRIEF.md
# Timer-Triggered Stepper Pattern Port

This block drives eight output pins arranged as two groups of four. Each group is intended to step a motor: software loads the next four-bit pattern into a holding register for the group, and the pattern moves onto the pins only when that group's 16-bit down-counter expires. Pin edges are therefore aligned to the timer and not to software write timing, so the phase sequence keeps its timing even if software is late, as long as it writes before the next expiry.

Each group has its own counter, reload value and clock-divider choice. All counters run from a shared prescaler that divides a base tick enable by 2, 16, 64 or 512. A mode register turns each group's pulse function on or off, can AND a group's pins with an external PWM signal (a separate PWM input per group), and can invert group 0 after the gating. A per-pin active flag tells the pad logic around the block which pins are in pulse mode.

Software writes the registers through a small write-only port. The address map is: 0 mode, 1 group 0 pattern, 2 group 1 pattern, 3 divider select, 4 group 0 reload, 5 group 1 reload.

Top module: `pulse_step_port`

## Requirements
- R1: While rstN is low, and right after it is released, pinOut and pinActive are all zero, and every counter, pattern, latch and mode field is zero.
- R2: Mode bit 1 sets pinActive[3:0] (group 0) and mode bit 0 sets pinActive[7:4] (group 1). A mode value of 0 leaves every flag low and 3 sets all eight.
- R3: At the clock edge where group g's counter expires, the pins of group g (group 0 on pinOut[3:0], group 1 on pinOut[7:4]) take the pattern held at that moment (write address 1 for group 0, address 2 for group 1, data bits 3:0).
- R4: Each group's 16-bit counter changes only on its divided tick. On a tick it decrements if it is nonzero. If it is zero on a tick, that tick is the expiry: the counter loads the group's reload value (address 4 or 5, data bits 15:0). The counter is zero after reset, so the first tick is an expiry, and after that the group expires once every reload+1 ticks.
- R5: A shared prescaler counts cycles in which baseTick is high. Divider select (address 3: bits 1:0 for group 0, bits 3:2 for group 1) picks a divisor of 2, 16, 64 or 512 for codes 00, 01, 10 and 11. A group's tick is the baseTick cycle that brings the count of baseTick cycles since reset to a multiple of its divisor.
- R6: With mode bit 4 set, each group 0 pin is the AND of its latched bit and pwm0In. With mode bit 5 set, each group 1 pin is the AND of its latched bit and pwm1In. These pins follow the PWM inputs in the same cycle.
- R7: With mode bit 3 set, group 0 pins output the complement of the value after gating. Group 1 pins are never inverted.
- R8: A pattern write never changes the pins on its own. The pins keep their value until that group's next expiry.
- R9: A group that is not selected in mode still drives its latched, gated and inverted value on pinOut. Only its active flags are low.
- R10: A reload write does not touch a running counter. The new value is used from the next expiry onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | Base count enable fed to the prescaler |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| pwm0In | input | 1 | PWM gating source for group 0 |
| pwm1In | input | 1 | PWM gating source for group 1 |
| pinOut | output | 8 | Pattern pins, group 0 in bits 3:0 |
| pinActive | output | 8 | Per-pin pulse-mode active flag |

## Verification
The bench targets the moments that expose off-by-one errors. A counter that reloads one tick early or late makes the pins change one tick away from the model's expiry. A design that loads a pattern in the same cycle it is written moves the pins while baseTick is held low. A design that loads a new reload value into a running counter shifts the next expiry. The bench also drives random PWM levels and random baseTick gaps with every divider code. This catches a swapped gating source, inversion placed before the AND, inversion wrongly applied to group 1, and a prescaler tap that is off by one bit.

// File: rtl/pso_pkg.sv
package pso_pkg;
  localparam int GRP_N  = 2;
  localparam int PIN_W  = 4;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;
  localparam int BUS_W  = 16;
  localparam int PRE_W  = 9;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_DAT0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_PSEL = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD0 = 3'd4;

  typedef struct packed {
    logic pwm1En;
    logic pwm0En;
    logic pol0;
    logic selG0;
    logic selG1;
  } mode_t;

  typedef struct packed {
    logic [GRP_N-1:0] trig;
  } strobe_t;

  // number of low prescaler bits that must be all ones for a tap
  function automatic int tapBits(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 6;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/pso_timer.sv
module pso_timer #(
  parameter int CW = pso_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic [CW-1:0] reloadVal,
  output logic          trig
);
  logic [CW-1:0] cnt;

  assign trig = tickEn && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (tickEn) begin
      if (cnt == '0) cnt <= reloadVal;
      else           cnt <= cnt - 1'b1;
    end
  end

  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> cnt == $past(reloadVal)); // R4
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cnt)); // R10
endmodule

// File: rtl/pso_ctrl.sv
module pso_ctrl
  import pso_pkg::*;
#(
  parameter int NG = GRP_N,
  parameter int CW = CNT_W,
  parameter int AW = ADDR_W,
  parameter int BW = BUS_W,
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          baseTick,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [BW-1:0] wrData,
  output strobe_t       strb
);
  logic [PW-1:0] preCnt;
  logic [1:0]    selReg [NG];
  logic [CW-1:0] rldReg [NG];
  logic [NG-1:0] tickEn;
  logic [NG-1:0] trigVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (baseTick) begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < NG; g++) begin
      if (!rstN) begin
        selReg[g] <= '0;
        rldReg[g] <= '0;
      end else if (wrEn) begin
        if (wrAddr == A_PSEL) selReg[g] <= wrData[2*g +: 2];
        if (wrAddr == AW'(A_RLD0 + g)) rldReg[g] <= wrData[CW-1:0];
      end
    end
  end

  for (genvar g = 0; g < NG; g++) begin : gTmr
    logic [PW-1:0] tapMask;
    always_comb begin
      tapMask   = PW'((1 << tapBits(selReg[g])) - 1);
      tickEn[g] = baseTick && ((preCnt & tapMask) == tapMask);
    end

    pso_timer #(.CW(CW)) uTmr (
      .clk      (clk),
      .rstN     (rstN),
      .tickEn   (tickEn[g]),
      .reloadVal(rldReg[g]),
      .trig     (trigVec[g])
    );

    AST_TICK_NEEDS_BASE: assert property (@(posedge clk) disable iff (!rstN)
      tickEn[g] |-> baseTick); // R5
    AST_TRIG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
      trigVec[g] |-> tickEn[g]); // R4
  end

  assign strb.trig = trigVec;
endmodule

// File: rtl/pso_datapath.sv
module pso_datapath
  import pso_pkg::*;
#(
  parameter int NG = GRP_N,
  parameter int PN = PIN_W,
  parameter int AW = ADDR_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [AW-1:0]  wrAddr,
  input  mode_t          modeWr,
  input  logic [PN-1:0]  nibWr,
  input  strobe_t        strb,
  input  logic [NG-1:0]  pwmIn,
  output logic [NG*PN-1:0] pinOut,
  output logic [NG*PN-1:0] pinActive
);
  mode_t         modeR;
  logic [PN-1:0] dataR  [NG];
  logic [PN-1:0] latchR [NG];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeR <= '0;
    end else if (wrEn && wrAddr == A_MODE) begin
      modeR <= modeWr;
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < NG; g++) begin
      if (!rstN) begin
        dataR[g]  <= '0;
        latchR[g] <= '0;
      end else begin
        if (wrEn && wrAddr == AW'(A_DAT0 + g)) dataR[g] <= nibWr;
        if (strb.trig[g]) latchR[g] <= dataR[g];
      end
    end
  end

  for (genvar g = 0; g < NG; g++) begin : gGrp
    logic          gateEn;
    logic          invEn;
    logic          actEn;
    logic [PN-1:0] gated;

    if (g == 0) begin : gFirst
      assign gateEn = modeR.pwm0En;
      assign invEn  = modeR.pol0;
      assign actEn  = modeR.selG0;
    end else begin : gOther
      assign gateEn = modeR.pwm1En;
      assign invEn  = 1'b0;
      assign actEn  = modeR.selG1;
    end

    always_comb begin
      gated = latchR[g] & (gateEn ? {PN{pwmIn[g]}} : {PN{1'b1}});
      pinOut[g*PN +: PN]    = invEn ? ~gated : gated;
      pinActive[g*PN +: PN] = {PN{actEn}};
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !strb.trig[g] |=> $stable(latchR[g])); // R8
    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      strb.trig[g] |=> latchR[g] == $past(dataR[g])); // R3
    AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rstN)
      (gateEn && !pwmIn[g] && !invEn) |-> pinOut[g*PN +: PN] == '0); // R6
  end
endmodule

// File: rtl/pulse_step_port.sv
module pulse_step_port
  import pso_pkg::*;
#(
  parameter int NG = GRP_N,
  parameter int PN = PIN_W,
  parameter int CW = CNT_W,
  parameter int AW = ADDR_W,
  parameter int BW = BUS_W,
  parameter int PW = PRE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baseTick,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [BW-1:0]    wrData,
  input  logic             pwm0In,
  input  logic             pwm1In,
  output logic [NG*PN-1:0] pinOut,
  output logic [NG*PN-1:0] pinActive
);
  strobe_t strb;
  mode_t   modeWr;

  assign modeWr.selG1  = wrData[0];
  assign modeWr.selG0  = wrData[1];
  assign modeWr.pol0   = wrData[3];
  assign modeWr.pwm0En = wrData[4];
  assign modeWr.pwm1En = wrData[5];

  pso_ctrl #(.NG(NG), .CW(CW), .AW(AW), .BW(BW), .PW(PW)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .baseTick(baseTick),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strb    (strb)
  );

  pso_datapath #(.NG(NG), .PN(PN), .AW(AW)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .modeWr   (modeWr),
    .nibWr    (wrData[PN-1:0]),
    .strb     (strb),
    .pwmIn    ({pwm1In, pwm0In}),
    .pinOut   (pinOut),
    .pinActive(pinActive)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (pinActive == '0)); // R1
endmodule

// File: tb/sim_pulse_step_port.sv
`timescale 1ns/1ps
module sim_pulse_step_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic       pwm0In = 1'b0;
  logic       pwm1In = 1'b0;
  logic [7:0] pinOut;
  logic [7:0] pinActive;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string curReq = "R1";

  // behavioural reference state
  int mPre;
  int mCnt[2];
  int mRld[2];
  int mSel[2];
  int mDat[2];
  int mLat[2];
  int mMode;

  always #2.5 clk = ~clk;

  pulse_step_port u0 (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .pwm0In(pwm0In), .pwm1In(pwm1In),
    .pinOut(pinOut), .pinActive(pinActive)
  );

  function automatic int divOf(input int s);
    case (s)
      0: return 2;
      1: return 16;
      2: return 64;
      default: return 512;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mMode = 0;
      for (int g = 0; g < 2; g++) begin
        mCnt[g] = 0; mRld[g] = 0; mSel[g] = 0; mDat[g] = 0; mLat[g] = 0;
      end
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (baseTick && ((mPre + 1) % divOf(mSel[g]) == 0)) begin
          if (mCnt[g] == 0) begin
            mLat[g] = mDat[g];
            mCnt[g] = mRld[g];
          end else begin
            mCnt[g] = mCnt[g] - 1;
          end
        end
      end
      if (baseTick) mPre = (mPre + 1) % 512;
      if (wrEn) begin
        case (wrAddr)
          3'd0: mMode = int'(wrData[5:0]);
          3'd1: mDat[0] = int'(wrData[3:0]);
          3'd2: mDat[1] = int'(wrData[3:0]);
          3'd3: begin mSel[0] = int'(wrData[1:0]); mSel[1] = int'(wrData[3:2]); end
          3'd4: mRld[0] = int'(wrData);
          3'd5: mRld[1] = int'(wrData);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the model every cycle, away from the rising edge
  always @(negedge clk) begin
    logic [3:0] gated0, gated1, lat0, lat1;
    logic [7:0] expOut, expAct;
    lat0 = 4'(mLat[0]);
    lat1 = 4'(mLat[1]);
    gated0 = lat0 & (mMode[4] ? {4{pwm0In}} : 4'hF);
    gated1 = lat1 & (mMode[5] ? {4{pwm1In}} : 4'hF);
    expOut = {gated1, (mMode[3] ? ~gated0 : gated0)};
    expAct = {{4{mMode[0]}}, {4{mMode[1]}}};
    chk(curReq, "pinOut", pinOut, expOut);
    chk(curReq, "pinActive", pinActive, expAct);
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic run(input int n, input bit rndTick, input bit rndPwm);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      baseTick = rndTick ? 1'($urandom) : 1'b1;
      if (rndPwm) begin
        pwm0In = 1'($urandom);
        pwm1In = 1'($urandom);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    // R1: reset state
    curReq = "R1";
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "pinOut in reset", pinOut, 8'h00);
    chk("R1", "pinActive in reset", pinActive, 8'h00);
    @(posedge clk); #1; rstN = 1'b1;
    @(negedge clk);
    chk("R1", "pinOut after release", pinOut, 8'h00);

    // R2 R3 R4: both groups, fastest divider
    curReq = "R3";
    wr(3'd4, 16'd3);
    wr(3'd5, 16'd1);
    wr(3'd1, 16'h5);
    wr(3'd2, 16'hA);
    wr(3'd0, 16'h0003);
    curReq = "R4";
    run(40, 0, 0);
    @(negedge clk);
    chk("R2", "both groups active", pinActive, 8'hFF);

    // R8: a pattern write with no tick leaves the pins alone
    curReq = "R8";
    @(posedge clk); #1; baseTick = 1'b0;
    @(negedge clk); held = pinOut;
    wr(3'd1, 16'hC);
    wr(3'd2, 16'h3);
    repeat (3) @(negedge clk);
    chk("R8", "pins after pattern write", pinOut, held);
    run(30, 0, 0);

    // R6: gating by each PWM source
    curReq = "R6";
    wr(3'd0, 16'h0033);
    run(80, 1, 1);

    // R7: inversion of group 0 only, with and without gating
    curReq = "R7";
    wr(3'd0, 16'h003B);
    run(60, 1, 1);
    wr(3'd0, 16'h000B);
    run(40, 1, 1);

    // R2 R9: single groups and none selected
    curReq = "R9";
    wr(3'd0, 16'h0001);
    run(20, 0, 0);
    @(negedge clk);
    chk("R2", "group 1 only", pinActive, 8'hF0);
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'h9);
    run(20, 0, 0);
    @(negedge clk);
    chk("R2", "group 0 only", pinActive, 8'h0F);
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h6);
    run(20, 0, 0);
    @(negedge clk);
    chk("R9", "unselected group 1 still driven", pinOut[7:4], 4'h6);
    chk("R2", "none selected", pinActive, 8'h00);

    // R10: reload changed while counting
    curReq = "R10";
    wr(3'd0, 16'h0003);
    wr(3'd4, 16'd7);
    run(5, 0, 0);
    wr(3'd4, 16'd2);
    wr(3'd1, 16'h1);
    run(40, 0, 0);

    // R5: every divider code with gaps in baseTick
    curReq = "R5";
    wr(3'd4, 16'd2);
    wr(3'd5, 16'd1);
    wr(3'd3, 16'h0009);
    wr(3'd1, 16'h7);
    wr(3'd2, 16'hE);
    run(800, 1, 0);
    wr(3'd3, 16'h000E);
    wr(3'd1, 16'h2);
    wr(3'd2, 16'h1);
    run(5000, 1, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule